// File: doc/BRIEF.md
# Start-Flag Serial to Trigger Handshake Converter

This block links a producer that sends a two-field record over a start-flagged serial link to a consumer that expects the record on a trigger handshake. Each record has two bytes, field a and then field b. On the input, any number of idle cycles (start low, bus ignored) may come first. A cycle with start high carries field a, and the cycle right after it carries field b. On the output, wait cycles (trigger low) come first, then trigger high with field a, then trigger low with field b.

The converter is a four-state machine with states IDLE, GRAB_B, BEAT_A and BEAT_B. The transitions are: IDLE to GRAB_B on start high (capture a); GRAB_B to BEAT_A always (capture b); BEAT_A to BEAT_B always; BEAT_B to IDLE always. Both fields are registered before the output begins, so latency is fixed. A busy flag tells the producer that a record is in flight. A start that arrives while busy is dropped and recorded in a sticky overrun flag.

Top module: `ser2hs_conv`

## Requirements
- R1: While no record is in flight, the output shows trigger 0 and data 0, whatever the input bus carries on cycles with start 0.
- R2: A start=1 cycle seen while not busy captures the bus as field a, and busy reads 1 in the next cycle.
- R3: The cycle after the field a capture always captures the bus as field b, even when start is 1 on that cycle. A start of 1 on that cycle also sets the overrun flag.
- R4: The field a beat (trigger 1, data = a) appears exactly two cycles after the start cycle and lasts exactly one cycle.
- R5: The cycle after the a beat shows trigger 0 with data = b for exactly one cycle, and the output then returns to trigger 0 and data 0.
- R6: Busy is 1 for exactly the three cycles from the cycle after the start through the b beat, and 0 otherwise.
- R7: A start=1 cycle that arrives while busy produces no record on the output and sets overrun. Overrun stays 1 until reset.
- R8: A synchronous active-high reset returns the machine to IDLE with trigger 0, data 0, busy 0 and overrun 0.
- R9: A new start can be accepted in the cycle right after the b beat, which gives back-to-back records every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | Serial start flag: high marks the field a cycle |
| in_data | input | DATA_W | Serial data bus |
| busy | output | 1 | A record is in flight; new starts are dropped |
| overrun | output | 1 | Sticky: a start arrived while busy |
| out_trig | output | 1 | Handshake trigger |
| out_data | output | DATA_W | Handshake data bus |

## Verification
The assertions check these relations on every cycle: trigger never stays high for two cycles, the output is zero whenever busy is low, an accepted start leads to busy and then to an a beat carrying the captured byte two cycles later, and overrun sets and then sticks. Some behaviours only the bench scenarios can show. These are the values of field b under different input patterns, that dropped starts never produce an output record, the spacing of back-to-back records, and the clearing done by reset.

// File: rtl/ser2hs_pkg.sv
package ser2hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRAB_B = 2'd1,
        ST_BEAT_A = 2'd2,
        ST_BEAT_B = 2'd3
    } conv_state_e;

endpackage

// File: rtl/ser2hs_fsm.sv
module ser2hs_fsm
    import ser2hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic cap_a,
    output logic cap_b,
    output logic beat_a,
    output logic beat_b,
    output logic busy,
    output logic drop
);

    conv_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_GRAB_B;
            ST_GRAB_B: state_d = ST_BEAT_A;
            ST_BEAT_A: state_d = ST_BEAT_B;
            ST_BEAT_B: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // decoded outputs
    always_comb begin
        cap_a  = 1'b0;
        cap_b  = 1'b0;
        beat_a = 1'b0;
        beat_b = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy  = 1'b0;
                cap_a = start;
            end
            ST_GRAB_B: cap_b  = 1'b1;
            ST_BEAT_A: beat_a = 1'b1;
            ST_BEAT_B: beat_b = 1'b1;
            default:   busy   = 1'b0;
        endcase
        drop = busy & start;
    end

endmodule

// File: rtl/ser2hs_hold.sv
module ser2hs_hold #(
    parameter int DATA_W = 8,
    parameter int FIELDS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FIELDS-1:0] load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] field_q [FIELDS]
);

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)          field_q[g] <= '0;
            else if (load[g]) field_q[g] <= din;
        end
    end

endmodule

// File: rtl/ser2hs_drive.sv
module ser2hs_drive #(
    parameter int DATA_W = 8
) (
    input  logic              beat_a,
    input  logic              beat_b,
    input  logic [DATA_W-1:0] fld_a,
    input  logic [DATA_W-1:0] fld_b,
    output logic              trig,
    output logic [DATA_W-1:0] data
);

    always_comb begin
        trig = beat_a;
        if (beat_a)      data = fld_a;
        else if (beat_b) data = fld_b;
        else             data = '0;
    end

endmodule

// File: rtl/ser2hs_sticky.sv
module ser2hs_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
    end

endmodule

// File: rtl/ser2hs_conv.sv
module ser2hs_conv #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_start,
    input  logic [DATA_W-1:0] in_data,
    output logic              busy,
    output logic              overrun,
    output logic              out_trig,
    output logic [DATA_W-1:0] out_data
);

    localparam int NFIELD = 2;

    logic cap_a, cap_b, beat_a, beat_b, drop;
    logic [DATA_W-1:0] fields [NFIELD];

    ser2hs_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (in_start),
        .cap_a  (cap_a),
        .cap_b  (cap_b),
        .beat_a (beat_a),
        .beat_b (beat_b),
        .busy   (busy),
        .drop   (drop)
    );

    ser2hs_hold #(.DATA_W(DATA_W), .FIELDS(NFIELD)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    ({cap_b, cap_a}),
        .din     (in_data),
        .field_q (fields)
    );

    ser2hs_drive #(.DATA_W(DATA_W)) u_drive (
        .beat_a (beat_a),
        .beat_b (beat_b),
        .fld_a  (fields[0]),
        .fld_b  (fields[1]),
        .trig   (out_trig),
        .data   (out_data)
    );

    ser2hs_sticky u_ovr (
        .clk  (clk),
        .rst  (rst),
        .set  (drop),
        .flag (overrun)
    );

endmodule

// File: rtl/ser2hs_conv_chk.sv
module ser2hs_conv_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_start,
    input logic [DATA_W-1:0] in_data,
    input logic              busy,
    input logic              overrun,
    input logic              out_trig,
    input logic [DATA_W-1:0] out_data
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_trig && out_data == '0));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_start) |=> busy);

    p_beat_a_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_start) |=> ##1 (out_trig && out_data == $past(in_data, 2)));

    p_single_trig_r4: assert property (@(posedge clk) disable iff (rst)
        out_trig |=> !out_trig);

    p_b_busy_r6: assert property (@(posedge clk) disable iff (rst)
        out_trig |=> busy);

    p_after_b_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(out_trig) |=> (!busy && out_data == '0));

    p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && in_start) |=> overrun);

    p_overrun_hold_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind ser2hs_conv ser2hs_conv_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_start (in_start),
    .in_data  (in_data),
    .busy     (busy),
    .overrun  (overrun),
    .out_trig (out_trig),
    .out_data (out_data)
);

// File: tb/ser2hs_conv_bench.sv
module ser2hs_conv_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_start = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         busy, overrun, out_trig;
    logic [W-1:0] out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        int           when;
    } rec_t;
    rec_t sb[$];
    bit          pend_b = 1'b0;
    logic [W-1:0] exp_b = '0;

    ser2hs_conv #(.DATA_W(W)) u_ser2hs_conv (
        .clk(clk), .rst(rst), .in_start(in_start), .in_data(in_data),
        .busy(busy), .overrun(overrun), .out_trig(out_trig), .out_data(out_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: compares the output stream against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_trig) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 unexpected record", 32'(out_data), 0);
                end else begin
                    rec_t r;
                    r = sb.pop_front();
                    chk(out_data == r.a, "R4 a beat data", 32'(out_data), 32'(r.a));
                    chk(cyc == r.when, "R4 a beat timing", cyc, r.when);
                    exp_b  = r.b;
                    pend_b = 1'b1;
                end
            end else if (pend_b) begin
                chk(out_data == exp_b, "R5 b beat data", 32'(out_data), 32'(exp_b));
                pend_b = 1'b0;
            end else begin
                chk(out_data == '0, "R1 idle data", 32'(out_data), 0);
            end
        end
    end

    // drive one record; returns after four cycles, ready for the next start
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit start_on_b, input bit extra_start);
        @(negedge clk);
        in_start = 1'b1; in_data = a;
        sb.push_back('{a: a, b: b, when: cyc + 2});
        @(negedge clk);
        in_start = start_on_b; in_data = b;
        @(negedge clk);
        in_start = extra_start; in_data = 8'hE7;
        @(negedge clk);
        in_start = 1'b0; in_data = 8'h3C;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_start = 1'b0; in_data = W'(i * 37 + 5);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; in_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!out_trig && out_data == '0, "R8 reset output", {out_trig, out_data}, 0);
        chk(!busy, "R8 reset busy", busy, 0);
        chk(!overrun, "R8 reset overrun", overrun, 0);
    endtask

    initial begin
        do_reset();
        // R1: idle with junk on the bus
        idle(6);
        chk(!busy, "R1 idle busy", busy, 0);

        // R2/R6: busy profile of one record
        @(negedge clk);
        in_start = 1'b1; in_data = 8'hA1;
        sb.push_back('{a: 8'hA1, b: 8'h5B, when: cyc + 2});
        @(negedge clk);
        chk(busy, "R2 busy after start", busy, 1);
        in_start = 1'b0; in_data = 8'h5B;
        @(negedge clk);
        chk(busy, "R6 busy on a beat", busy, 1);
        in_data = 8'h00;
        @(negedge clk);
        chk(busy, "R6 busy on b beat", busy, 1);
        @(negedge clk);
        chk(!busy, "R6 busy low after b beat", busy, 0);
        chk(!overrun, "R7 no overrun on legal traffic", overrun, 0);

        // R9: back-to-back records
        send(8'h11, 8'h22, 1'b0, 1'b0);
        send(8'hFF, 8'h00, 1'b0, 1'b0);
        send(8'h80, 8'h7F, 1'b0, 1'b0);
        idle(3);
        chk(sb.size() == 0, "R9 back-to-back all delivered", sb.size(), 0);
        chk(!overrun, "R9 no overrun back-to-back", overrun, 0);

        // R3: start high on the b cycle still captures b and flags overrun
        send(8'hC3, 8'h3C, 1'b1, 1'b0);
        idle(3);
        chk(overrun, "R3 overrun on start during b", overrun, 1);
        chk(sb.size() == 0, "R3 record delivered", sb.size(), 0);

        // R8: reset clears overrun
        do_reset();

        // R7: start during a beat dropped, overrun set and sticky
        send(8'h5A, 8'hA5, 1'b0, 1'b1);
        idle(1);
        chk(overrun, "R7 overrun set", overrun, 1);
        idle(8);
        chk(overrun, "R7 overrun sticky", overrun, 1);
        chk(sb.size() == 0, "R7 only legal record delivered", sb.size(), 0);
        chk(!busy, "R7 idle after drop", busy, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule